// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

This block is one channel of a DMA engine. It moves a run of equal-sized elements between a device register, whose address never changes, and a memory buffer, whose address moves forward by one element width per element. Each run is described by a four-word descriptor: device address, memory address, size word and next word. The engine either takes the first descriptor straight from its four register inputs (single-shot mode) or takes only the next-pointer input and fetches every descriptor from memory (linked mode). After any descriptor, the two low bits of its next word decide whether another descriptor is fetched and whether a completion pulse is raised.

Memory traffic uses one request channel with valid/ready handshaking and a read-data return strobe. A request, once raised, keeps its address, write flag, width and data unchanged until the cycle in which ready is high. The engine keeps at most one read outstanding. It always accepts read data in the cycle that `mem_rsp_valid_i` is high, so the return path has no ready. Every element is moved as a read of the source followed by a write of the same data to the destination.

Top module: `dmac_chain_engine`

## Requirements
- R1: In linked mode, a start fetches the descriptor with four 4-byte reads (width code 2) at the pointer and the pointer plus 4, 8 and 12, in that order. The pointer is `reg_next_i` with bits 1:0 cleared. The words are taken as device address, memory address, size and next.
- R2: In single-shot mode (mode 2), the first descriptor is taken from `reg_dev_i`, `reg_mem_i`, `reg_size_i` and `reg_next_i` at the start, and no descriptor read is issued for it.
- R3: Size bits 13:12 select the element width: 3 is 1 byte, 2 is 2 bytes and 0 is 4 bytes. `mem_req_width_o` reports the width as log2 of its byte count (0, 1 or 2). Bits 10:0 hold the element count.
- R4: With `dir_i` = 1 at start, each element is read from the memory address and written to the device address. With `dir_i` = 0, it is read from the device address and written to the memory address. The write data equals the data returned by the read.
- R5: The device address is the same for every element of a descriptor. The memory address starts at the descriptor's memory word and grows by the element's byte count after each element.
- R6: At the end of a descriptor, next bit 0 set raises `done_o` for one cycle. Next bit 1 set fetches the next descriptor at the next word with bits 1:0 cleared; bit 1 clear returns the channel to idle.
- R7: A descriptor with a count of zero makes no element access and still handles its next word as in R6.
- R8: Width code 1, or a count above 0x3FF with a 1- or 2-byte width, raises `err_o` and `done_o` in the same cycle and sends the channel idle without element accesses. Counts up to 0x3FF (1 or 2 bytes) and up to 0x7FF (4 bytes) are legal.
- R9: `state_o` reads 0 when idle, 1 while a descriptor is fetched or checked, 2 while waiting for element read data, and 3 while element requests are made. No request is raised while it reads 0 or 2.
- R10: A start is honoured only while idle with mode 1 or 2. A start while busy does not change the request stream of the run in progress.
- R11: Mode 0 or 3 while busy returns the channel to idle at the next clock edge, drops any request and raises no pulse.
- R12: A request that is not accepted stays unchanged until ready is high, and at most one read is outstanding.
- R13: After reset the channel is idle with no request and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 off, 1 linked, 2 single-shot, 3 off |
| dir_i | input | 1 | 1: memory to device, 0: device to memory (sampled at start) |
| start_i | input | 1 | Start strobe |
| reg_dev_i | input | 32 | Device address for single-shot start |
| reg_mem_i | input | 32 | Memory address for single-shot start |
| reg_size_i | input | 32 | Size word for single-shot start |
| reg_next_i | input | 32 | Next word / descriptor pointer |
| state_o | output | 2 | Channel state code |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Error pulse |
| mem_req_valid_o | output | 1 | Request valid |
| mem_req_ready_i | input | 1 | Request accepted this cycle |
| mem_req_we_o | output | 1 | 1 write, 0 read |
| mem_req_addr_o | output | 32 | Request byte address |
| mem_req_width_o | output | 2 | log2 of access bytes |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |

## Verification
The channel is driven with short single-shot runs in both directions, linked chains whose descriptors mix all three widths, chains with a zero-count link, and random chains of one to three descriptors with random ready stalls and read latencies. Each pattern separates a different fault. Direction runs expose swapped source and destination. Mixed widths expose a wrong address step or width code. Zero counts and stalls expose element accesses that should not occur or requests that move while stalled. Directed cases cover the reserved width, a count just over the narrow limit, both legal maximum counts, a start while busy and an abort mid-run.

// File: rtl/dmac_chain_pkg.sv
package dmac_chain_pkg;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned IDX_DEV    = 0;
  localparam int unsigned IDX_MEM    = 1;
  localparam int unsigned IDX_SIZE   = 2;
  localparam int unsigned IDX_NEXT   = 3;
  localparam logic [1:0]  LG_WORD    = 2'd2;

  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_DESC   = 2'd1,
    CH_WAIT   = 2'd2,
    CH_ACCESS = 2'd3
  } ch_status_e;

  typedef enum logic [1:0] {
    RUN_OFF    = 2'd0,
    RUN_LINKED = 2'd1,
    RUN_SINGLE = 2'd2,
    RUN_RSVD   = 2'd3
  } run_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FREQ, SQ_FWAIT, SQ_CHECK, SQ_RREQ, SQ_RWAIT, SQ_WREQ, SQ_END
  } seq_state_e;
endpackage

// File: rtl/dmac_size_decode.sv
module dmac_size_decode #(
  parameter int WORD_W  = 32,
  parameter int CNT_W   = 11,
  parameter int WID_LSB = 12
) (
  input  logic [WORD_W-1:0] size_word,
  output logic [CNT_W-1:0]  count,
  output logic [1:0]        lg_bytes,
  output logic              bad
);
  logic [1:0] code;
  logic       narrow_over;

  assign code        = size_word[WID_LSB+1:WID_LSB];
  assign count       = size_word[CNT_W-1:0];
  // narrow widths allow only half the count range
  assign narrow_over = size_word[CNT_W-1];

  always_comb begin
    lg_bytes = 2'd2;
    bad      = 1'b0;
    case (code)
      2'd3:    begin lg_bytes = 2'd0; bad = narrow_over; end
      2'd2:    begin lg_bytes = 2'd1; bad = narrow_over; end
      2'd0:    lg_bytes = 2'd2;
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/dmac_desc_bank.sv
module dmac_desc_bank #(
  parameter  int WORD_W = 32,
  parameter  int NWORDS = 4,
  localparam int IDX_W  = $clog2(NWORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_all,
  input  logic [NWORDS-1:0][WORD_W-1:0] all_words,
  input  logic                          load_one,
  input  logic [IDX_W-1:0]              one_idx,
  input  logic [WORD_W-1:0]             one_word,
  output logic [NWORDS-1:0][WORD_W-1:0] words
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      q <= '0;
      else if (load_all)                               q <= all_words[g];
      else if (load_one && one_idx == IDX_W'(g))       q <= one_word;
    end
    assign words[g] = q;
  end
endmodule

// File: rtl/dmac_elem_track.sv
module dmac_elem_track #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  logic              step,
  input  logic [1:0]        lg_bytes,
  output logic [WORD_W-1:0] cur_addr,
  output logic              last
);
  logic [WORD_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load) begin
      addr_q <= base;
      left_q <= count;
    end else if (step) begin
      addr_q <= addr_q + (WORD_W'(1) << lg_bytes);
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign cur_addr = addr_q;
  assign last     = (left_q == CNT_W'(1));
endmodule

// File: rtl/dmac_chain_engine.sv
module dmac_chain_engine
  import dmac_chain_pkg::*;
#(
  parameter  int WORD_W  = 32,
  parameter  int CNT_W   = 11,
  parameter  int WID_LSB = 12,
  localparam int IDX_W   = $clog2(DESC_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              dir_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] reg_dev_i,
  input  logic [WORD_W-1:0] reg_mem_i,
  input  logic [WORD_W-1:0] reg_size_i,
  input  logic [WORD_W-1:0] reg_next_i,
  output logic [1:0]        state_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [WORD_W-1:0] mem_req_addr_o,
  output logic [1:0]        mem_req_width_o,
  output logic [WORD_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [WORD_W-1:0] mem_rsp_data_i
);
  seq_state_e         seq_q;
  logic [WORD_W-1:0]  ptr_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WORD_W-1:0]  data_q;
  logic               dir_q;
  logic               done_q;
  logic               err_q;

  logic                              halt;
  logic                              load_regs;
  logic                              load_word;
  logic [DESC_WORDS-1:0][WORD_W-1:0] dw;
  logic [CNT_W-1:0]                  cnt;
  logic [1:0]                        lg;
  logic                              bad;
  logic [WORD_W-1:0]                 cur_mem;
  logic                              last_elem;
  logic                              step;
  logic [WORD_W-1:0]                 fetch_addr;
  logic [WORD_W-1:0]                 next_word;

  assign halt      = (mode_i == RUN_OFF) || (mode_i == RUN_RSVD);
  assign load_regs = (seq_q == SQ_IDLE) && start_i && (mode_i == RUN_SINGLE);
  assign load_word = (seq_q == SQ_FWAIT) && mem_rsp_valid_i;
  assign step      = (seq_q == SQ_WREQ) && mem_req_ready_i;
  assign next_word = dw[IDX_NEXT];
  assign fetch_addr = ptr_q + WORD_W'({idx_q, 2'b00});

  dmac_desc_bank #(.WORD_W(WORD_W), .NWORDS(DESC_WORDS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_all  (load_regs),
    .all_words ({reg_next_i, reg_size_i, reg_mem_i, reg_dev_i}),
    .load_one  (load_word),
    .one_idx   (idx_q),
    .one_word  (mem_rsp_data_i),
    .words     (dw)
  );

  dmac_size_decode #(.WORD_W(WORD_W), .CNT_W(CNT_W), .WID_LSB(WID_LSB)) u_dec (
    .size_word (dw[IDX_SIZE]),
    .count     (cnt),
    .lg_bytes  (lg),
    .bad       (bad)
  );

  dmac_elem_track #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (seq_q == SQ_CHECK),
    .base     (dw[IDX_MEM]),
    .count    (cnt),
    .step     (step),
    .lg_bytes (lg),
    .cur_addr (cur_mem),
    .last     (last_elem)
  );

  // sequencer: abort on an off mode has priority over every state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      ptr_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (seq_q != SQ_IDLE && halt) begin
        seq_q <= SQ_IDLE;
      end else begin
        case (seq_q)
          SQ_IDLE: if (start_i && !halt) begin
            dir_q <= dir_i;
            if (mode_i == RUN_LINKED) begin
              ptr_q <= {reg_next_i[WORD_W-1:2], 2'b00};
              idx_q <= '0;
              seq_q <= SQ_FREQ;
            end else begin
              seq_q <= SQ_CHECK;
            end
          end
          SQ_FREQ: if (mem_req_ready_i) seq_q <= SQ_FWAIT;
          SQ_FWAIT: if (mem_rsp_valid_i) begin
            if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
              seq_q <= SQ_CHECK;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              seq_q <= SQ_FREQ;
            end
          end
          SQ_CHECK: begin
            if (bad) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
              seq_q  <= SQ_IDLE;
            end else if (cnt == '0) begin
              seq_q <= SQ_END;
            end else begin
              seq_q <= SQ_RREQ;
            end
          end
          SQ_RREQ: if (mem_req_ready_i) seq_q <= SQ_RWAIT;
          SQ_RWAIT: if (mem_rsp_valid_i) begin
            data_q <= mem_rsp_data_i;
            seq_q  <= SQ_WREQ;
          end
          SQ_WREQ: if (mem_req_ready_i) seq_q <= last_elem ? SQ_END : SQ_RREQ;
          SQ_END: begin
            done_q <= next_word[0];
            if (next_word[1]) begin
              ptr_q <= {next_word[WORD_W-1:2], 2'b00};
              idx_q <= '0;
              seq_q <= SQ_FREQ;
            end else begin
              seq_q <= SQ_IDLE;
            end
          end
          default: seq_q <= SQ_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    mem_req_valid_o = 1'b0;
    mem_req_we_o    = 1'b0;
    mem_req_addr_o  = fetch_addr;
    mem_req_width_o = LG_WORD;
    case (seq_q)
      SQ_FREQ: mem_req_valid_o = 1'b1;
      SQ_RREQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = dir_q ? cur_mem : dw[IDX_DEV];
        mem_req_width_o = lg;
      end
      SQ_WREQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
        mem_req_addr_o  = dir_q ? dw[IDX_DEV] : cur_mem;
        mem_req_width_o = lg;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (seq_q)
      SQ_IDLE:                     state_o = CH_IDLE;
      SQ_FREQ, SQ_FWAIT, SQ_CHECK: state_o = CH_DESC;
      SQ_RWAIT:                    state_o = CH_WAIT;
      default:                     state_o = CH_ACCESS;
    endcase
  end

  assign mem_req_wdata_o = data_q;
  assign done_o          = done_q;
  assign err_o           = err_q;
endmodule

// File: rtl/dmac_chain_checks.sv
module dmac_chain_checks #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic [1:0]        state_o,
  input logic              done_o,
  input logic              err_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic              mem_req_we_o,
  input logic [WORD_W-1:0] mem_req_addr_o,
  input logic [1:0]        mem_req_width_o
);
  assert_fetch_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && state_o == 2'd1) |->
      (!mem_req_we_o && mem_req_width_o == 2'd2 && mem_req_addr_o[1:0] == 2'b00));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  assert_quiet_states_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 || state_o == 2'd2) |-> !mem_req_valid_o);

  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0 && (mode_i == 2'd0 || mode_i == 2'd3)) |=>
      (state_o == 2'd0 && !done_o && !err_o));

  assert_hold_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i && (mode_i == 2'd1 || mode_i == 2'd2)) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o)
       && $stable(mem_req_width_o)));
endmodule

bind dmac_chain_engine dmac_chain_checks #(.WORD_W(WORD_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mode_i          (mode_i),
  .state_o         (state_o),
  .done_o          (done_o),
  .err_o           (err_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_we_o    (mem_req_we_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_width_o (mem_req_width_o)
);

// File: tb/sim_dmac_chain_engine.sv
`timescale 1ns/1ps
module sim_dmac_chain_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        dir_i = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] reg_dev_i = '0, reg_mem_i = '0, reg_size_i = '0, reg_next_i = '0;
  logic [1:0]  state_o;
  logic        done_o, err_o;
  logic        mem_req_valid_o, mem_req_we_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o, mem_req_wdata_o;
  logic [1:0]  mem_req_width_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;

  always #2.5 clk = ~clk;

  dmac_chain_engine u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] dmem [logic [31:0]];
  logic [31:0] ex_addr[$];
  logic [31:0] ex_data[$];
  logic        ex_we[$];
  logic [1:0]  ex_w[$];
  int ex_done, ex_err, n_done, n_err;
  bit cmp_en = 1'b1;
  bit [3:0] seen;
  bit finished = 1'b0;

  // memory model state
  bit pend = 1'b0;
  int pdly;
  logic [31:0] pdata;

  function automatic logic [31:0] rd_word(logic [31:0] a);
    if (dmem.exists(a)) return dmem[a];
    return {~a[15:0], a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(logic we, logic [31:0] a, logic [1:0] w, logic [31:0] d);
    ex_we.push_back(we); ex_addr.push_back(a); ex_w.push_back(w); ex_data.push_back(d);
  endtask

  // walks the descriptor chain as the requirements define it
  task automatic build_expect(logic [1:0] mode, logic dir, logic [31:0] d0, m0, s0, n0);
    logic [31:0] dv, mm, sz, nx, ptr, ma, src, dst;
    logic [1:0] code, lg;
    int cnt;
    bit fetch;
    ex_done = 0; ex_err = 0;
    dv = d0; mm = m0; sz = s0; nx = n0;
    fetch = (mode == 2'd1);
    ptr = {n0[31:2], 2'b00};
    for (int k = 0; k < 16; k++) begin
      if (fetch) begin
        for (int i = 0; i < 4; i++) push(1'b0, ptr + 32'(4 * i), 2'd2, 32'd0);
        dv = rd_word(ptr); mm = rd_word(ptr + 4); sz = rd_word(ptr + 8); nx = rd_word(ptr + 12);
      end
      code = sz[13:12];
      cnt  = int'(sz[10:0]);
      if (code == 2'd1 || (code != 2'd0 && cnt > 32'h3FF)) begin
        ex_err++; ex_done++;
        break;
      end
      lg = (code == 2'd3) ? 2'd0 : (code == 2'd2) ? 2'd1 : 2'd2;
      ma = mm;
      for (int e = 0; e < cnt; e++) begin
        src = dir ? ma : dv;
        dst = dir ? dv : ma;
        push(1'b0, src, lg, 32'd0);
        push(1'b1, dst, lg, rd_word(src));
        ma = ma + (32'd1 << lg);
      end
      if (nx[0]) ex_done++;
      if (!nx[1]) break;
      ptr = {nx[31:2], 2'b00};
      fetch = 1'b1;
    end
  endtask

  task automatic run_job(logic [1:0] mode, logic dir, logic [31:0] d, m, s, n, int poke, string tag);
    ex_we.delete(); ex_addr.delete(); ex_w.delete(); ex_data.delete();
    build_expect(mode, dir, d, m, s, n);
    n_done = 0; n_err = 0; seen = '0;
    @(negedge clk);
    mode_i = mode; dir_i = dir;
    reg_dev_i = d; reg_mem_i = m; reg_size_i = s; reg_next_i = n;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      // R10: a start while busy with other registers must change nothing
      mode_i = 2'd2; dir_i = ~dir;
      reg_dev_i = 32'h4444_0000; reg_mem_i = 32'h0055_0000;
      reg_size_i = 32'h0000_3003; reg_next_i = 32'h1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int c = 0; c < 40000; c++) begin
      if (state_o == 2'd0) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(ex_addr.size() == 0, {tag, " R1 R4 R5 missing requests"}, 64'(ex_addr.size()), 64'd0);
    chk(n_done == ex_done, {tag, " R6 done pulses"}, 64'(n_done), 64'(ex_done));
    chk(n_err == ex_err, {tag, " R8 error pulses"}, 64'(n_err), 64'(ex_err));
    chk(state_o == 2'd0, {tag, " R9 idle at end"}, 64'(state_o), 64'd0);
  endtask

  task automatic put_desc(logic [31:0] at, logic [31:0] d, m, s, n);
    dmem[at] = d; dmem[at + 4] = m; dmem[at + 8] = s; dmem[at + 12] = n;
  endtask

  // memory model and request monitor, away from the active edge
  always @(negedge clk) begin
    logic [63:0] act, exp;
    logic e_we; logic [1:0] e_w; logic [31:0] e_a, e_d;
    if (!rst_n) begin
      mem_req_ready_i = 1'b0; mem_rsp_valid_i = 1'b0; pend = 1'b0;
    end else begin
      mem_rsp_valid_i = 1'b0;
      if (pend) begin
        if (pdly == 0) begin
          mem_rsp_valid_i = 1'b1; mem_rsp_data_i = pdata; pend = 1'b0;
        end else pdly--;
      end
      mem_req_ready_i = ($urandom % 4) != 0;
      if (mem_req_valid_o && mem_req_ready_i) begin
        if (!mem_req_we_o) begin
          pend = 1'b1; pdly = int'($urandom % 3); pdata = rd_word(mem_req_addr_o);
        end
        if (cmp_en) begin
          act = {mem_req_addr_o, mem_req_we_o ? mem_req_wdata_o : {29'd0, mem_req_we_o, mem_req_width_o}};
          if (ex_addr.size() == 0) begin
            chk(1'b0, "R10 R12 unexpected request", act, 64'd0);
          end else begin
            e_we = ex_we.pop_front(); e_a = ex_addr.pop_front();
            e_w = ex_w.pop_front(); e_d = ex_data.pop_front();
            exp = {e_a, e_we ? e_d : {29'd0, e_we, e_w}};
            chk(act == exp && mem_req_width_o == e_w, "R1 R3 R4 R5 R12 request", act, exp);
          end
        end
      end
      if (done_o) n_done++;
      if (err_o) n_err++;
      seen[state_o] = 1'b1;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] base, w_sz, w_nx;
    logic [1:0] code;
    int nd, r;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(state_o == 2'd0, "R13 state after reset", 64'(state_o), 64'd0);
    chk(!mem_req_valid_o, "R13 request after reset", 64'(mem_req_valid_o), 64'd0);
    chk(!done_o && !err_o, "R13 pulses after reset", 64'({done_o, err_o}), 64'd0);

    // R2 R4 R5: single-shot, memory to device, 4-byte, interrupt
    run_job(2'd2, 1'b1, 32'h4000_0010, 32'h0000_2000, 32'h0000_0005, 32'h1, 0, "R2 single m2d");
    // R3 R4: single-shot, device to memory, 1-byte, no interrupt
    run_job(2'd2, 1'b0, 32'h4000_0020, 32'h0000_3001, 32'h0000_3003, 32'h0, 0, "R3 single d2m");

    // R1 R6 R9: linked chain of three widths, pointer low bits set
    put_desc(32'h8000_0100, 32'h4100_0000, 32'h0001_0000, 32'h0000_2004, 32'h8000_0142);
    put_desc(32'h8000_0140, 32'h4100_0004, 32'h0001_1003, 32'h0000_3003, 32'h8000_0183);
    put_desc(32'h8000_0180, 32'h4100_0008, 32'h0001_2000, 32'h0000_0002, 32'h8000_0001);
    run_job(2'd1, 1'b1, 32'h0, 32'h0, 32'h0, 32'h8000_0103, 0, "R1 R6 linked");
    chk(seen[1] && seen[2] && seen[3], "R9 states seen in linked run", 64'(seen), 64'hF);

    // R7: zero-count link in the middle
    put_desc(32'h8000_0200, 32'h4200_0000, 32'h0002_0000, 32'h0000_0002, 32'h8000_0213);
    put_desc(32'h8000_0210, 32'h4200_0004, 32'h0002_1000, 32'h0000_0000, 32'h8000_0223);
    put_desc(32'h8000_0220, 32'h4200_0008, 32'h0002_2000, 32'h0000_2001, 32'h0000_0001);
    run_job(2'd1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h8000_0200, 0, "R7 zero count");

    // R8: reserved width, single-shot
    run_job(2'd2, 1'b1, 32'h4300_0000, 32'h0003_0000, 32'h0000_1005, 32'h1, 0, "R8 reserved width");
    // R8: 1-byte count just over the limit, second in a chain
    put_desc(32'h8000_0300, 32'h4300_0010, 32'h0003_1000, 32'h0000_0001, 32'h8000_0313);
    put_desc(32'h8000_0310, 32'h4300_0014, 32'h0003_2000, 32'h0000_3400, 32'h0000_0001);
    run_job(2'd1, 1'b1, 32'h0, 32'h0, 32'h0, 32'h8000_0300, 0, "R8 over limit");
    // R8 boundaries that are legal
    run_job(2'd2, 1'b1, 32'h4300_0020, 32'h0004_0000, 32'h0000_33FF, 32'h1, 0, "R8 max 1-byte");
    run_job(2'd2, 1'b0, 32'h4300_0024, 32'h0005_0000, 32'h0000_07FF, 32'h1, 0, "R8 max 4-byte");

    // R10: start while busy
    run_job(2'd2, 1'b1, 32'h4400_0000, 32'h0006_0000, 32'h0000_2008, 32'h1, 6, "R10 busy start");

    // R11: abort mid-run
    put_desc(32'h8000_0400, 32'h4500_0000, 32'h0007_0000, 32'h0000_0028, 32'h0000_0001);
    cmp_en = 1'b0;
    n_done = 0; n_err = 0;
    @(negedge clk);
    mode_i = 2'd1; reg_next_i = 32'h8000_0400; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (15) @(negedge clk);
    mode_i = 2'd0;
    @(negedge clk);
    chk(state_o == 2'd0, "R11 idle after abort", 64'(state_o), 64'd0);
    r = 0;
    repeat (8) begin
      @(negedge clk);
      if (mem_req_valid_o || state_o != 2'd0) r++;
    end
    chk(r == 0, "R11 no activity after abort", 64'(r), 64'd0);
    chk(n_done == 0 && n_err == 0, "R11 no pulse on abort", 64'(n_done + n_err), 64'd0);
    cmp_en = 1'b1;

    // random chains
    for (int j = 0; j < 30; j++) begin
      base = 32'h8000_1000 + 32'(j) * 32'h100;
      nd = 1 + int'($urandom % 3);
      for (int k = 0; k < nd; k++) begin
        r = int'($urandom % 12);
        code = (r == 0) ? 2'd1 : (r % 3 == 0) ? 2'd3 : (r % 3 == 1) ? 2'd2 : 2'd0;
        w_sz = {18'd0, code, 12'd0} | ($urandom % 7);
        w_nx = (k < nd - 1) ? ((base + 32'(16 * (k + 1))) | 32'h2) : 32'h0;
        w_nx = w_nx | ($urandom % 2);
        put_desc(base + 32'(16 * k), 32'h4800_0000 | ($urandom & 32'hFFFC),
                 $urandom & 32'h0FFF_FFF0, w_sz, w_nx);
      end
      if ($urandom % 2)
        run_job(2'd2, 1'($urandom % 2), dmem[base], dmem[base + 4], dmem[base + 8], dmem[base + 12], 0, "R4 random single");
      else
        run_job(2'd1, 1'($urandom % 2), 32'h0, 32'h0, 32'h0, base | ($urandom % 4), 0, "R1 random linked");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule